// File: doc/BRIEF.md
# Frame-Time Transaction Admission Gate

This block decides, cycle by cycle inside a USB frame, which class of transaction may start next. It keeps a 14-bit count of the bit-times left in the current frame. The count reloads from a programmable frame length at every start-of-frame strobe and counts down once per bit-time tick. Two software-programmed limits are compared against that count:

- a periodic start point, after which periodic (interrupt) work outranks control/bulk work;
- a low-speed cutoff, below which no low-speed transaction may be started, so that a short low-speed packet cannot run past the end of the frame.

The list walkers supply three request flags and a busy flag. The block answers with one-cycle grant pulses and a periodic-priority flag. Grants are issued only between transactions, so a control or bulk transfer that is already running is never cut short. A word-wide register port holds the frame length, the two limits and a read-only view of the live count.

Top module: `frame_admit_gate`

## Requirements
- R1: After reset the frame length register (offset 0x34) reads 0x2EDF, the periodic start register (offset 0x40) reads 0, the low-speed cutoff register (offset 0x44) reads 0x628, and no grant is asserted.
- R2: The periodic start register at offset 0x40 stores bits 13:0 of a write; bits 31:14 always read as zero, whatever was written.
- R3: The low-speed cutoff register at offset 0x44 stores bits 11:0 of a write; bits 31:12 always read as zero.
- R4: Unmapped offsets read as zero, and writes to them change no register. The remaining-count view at offset 0x38 is read-only.
- R5: A start-of-frame strobe loads the frame length into the remaining count, visible at 0x38 after the next clock edge, and takes precedence over a tick. Each tick lowers the count by one. Without a tick the count holds, and it stops at zero.
- R6: The periodic-priority flag rises one edge after the remaining count is at or below the periodic start value. It stays set for the rest of the frame and clears on the edge that takes a start-of-frame strobe.
- R7: While periodic priority is set, a periodic request wins over control/bulk and low-speed requests. With no periodic request, control/bulk is served next.
- R8: While periodic priority is clear, periodic requests are not granted, and a control/bulk request is granted.
- R9: A low-speed request has the lowest precedence. It is granted only when the remaining count at the deciding edge is greater than or equal to the low-speed cutoff; otherwise it is deferred.
- R10: Grants are one-hot, last one cycle, are decided only on an edge where the busy flag is low, and are never issued on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Start-of-frame strobe |
| tick_i | input | 1 | Bit-time tick |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from reg_addr_i) |
| per_req_i | input | 1 | Periodic work pending |
| cb_req_i | input | 1 | Control/bulk work pending |
| ls_req_i | input | 1 | Low-speed work pending |
| busy_i | input | 1 | A transaction is in progress |
| per_grant_o | output | 1 | Start periodic transaction (pulse) |
| cb_grant_o | output | 1 | Start control/bulk transaction (pulse) |
| ls_grant_o | output | 1 | Start low-speed transaction (pulse) |
| per_prio_o | output | 1 | Periodic work has priority in this frame |

## Verification
The bench steps the count across the periodic start point one tick at a time. A design that sets the flag one count early or late, or that fails to clear it on the start-of-frame edge, shows the wrong flag value on a known cycle. The low-speed cutoff is tested with the count exactly equal to the cutoff and then one below it. This catches a strict comparison or an off-by-one deferral. The bench also checks that control/bulk wins before the periodic start point, that periodic work wins after it, and that nothing is granted while busy or on the cycle right after a grant. Register tests write all-ones to confirm that the reserved bits read back as zero, and confirm that unmapped and read-only offsets ignore writes.

// File: rtl/frame_admit_pkg.sv
package frame_admit_pkg;
  localparam logic [7:0] OFF_FRAME_LEN = 8'h34;
  localparam logic [7:0] OFF_REMAIN    = 8'h38;
  localparam logic [7:0] OFF_PER_START = 8'h40;
  localparam logic [7:0] OFF_LS_CUT    = 8'h44;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_PER  = 2'd1,
    CLS_CB   = 2'd2,
    CLS_LS   = 2'd3
  } xfer_cls_e;

  typedef struct packed {
    logic per;
    logic cb;
    logic ls;
  } grant_t;
endpackage

// File: rtl/fa_regs.sv
module fa_regs
  import frame_admit_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_W    = 14,
  parameter int unsigned LS_W     = 12,
  parameter logic [CNT_W-1:0] FLEN_RST = 14'h2EDF,
  parameter logic [LS_W-1:0]  LSC_RST  = 12'h628
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  remain_i,
  output logic [CNT_W-1:0]  frame_len_o,
  output logic [CNT_W-1:0]  per_start_o,
  output logic [LS_W-1:0]   ls_cut_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] A_FLEN = ADDR_W'(OFF_FRAME_LEN);
  localparam logic [ADDR_W-1:0] A_REM  = ADDR_W'(OFF_REMAIN);
  localparam logic [ADDR_W-1:0] A_PS   = ADDR_W'(OFF_PER_START);
  localparam logic [ADDR_W-1:0] A_LSC  = ADDR_W'(OFF_LS_CUT);
  localparam int unsigned PAD_C = DATA_W - CNT_W;
  localparam int unsigned PAD_L = DATA_W - LS_W;

  logic [CNT_W-1:0] flen_q, ps_q;
  logic [LS_W-1:0]  lsc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flen_q <= FLEN_RST;
      ps_q   <= '0;
      lsc_q  <= LSC_RST;
    end else if (we_i) begin
      // reserved upper bits are dropped
      unique case (addr_i)
        A_FLEN:  flen_q <= wdata_i[CNT_W-1:0];
        A_PS:    ps_q   <= wdata_i[CNT_W-1:0];
        A_LSC:   lsc_q  <= wdata_i[LS_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      A_FLEN:  rdata_o = {{PAD_C{1'b0}}, flen_q};
      A_REM:   rdata_o = {{PAD_C{1'b0}}, remain_i};
      A_PS:    rdata_o = {{PAD_C{1'b0}}, ps_q};
      A_LSC:   rdata_o = {{PAD_L{1'b0}}, lsc_q};
      default: rdata_o = '0;
    endcase
  end

  assign frame_len_o = flen_q;
  assign per_start_o = ps_q;
  assign ls_cut_o    = lsc_q;
endmodule

// File: rtl/fa_frame_counter.sv
module fa_frame_counter #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] frame_len_i,
  output logic [CNT_W-1:0] remain_o
);
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  rem_q <= '0;
    else if (sof_i)               rem_q <= frame_len_i;
    else if (tick_i && rem_q != '0) rem_q <= rem_q - 1'b1;
  end

  assign remain_o = rem_q;
endmodule

// File: rtl/fa_arbiter.sv
module fa_arbiter
  import frame_admit_pkg::*;
#(
  parameter int unsigned CNT_W = 14,
  parameter int unsigned LS_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic [CNT_W-1:0] remain_i,
  input  logic [CNT_W-1:0] per_start_i,
  input  logic [LS_W-1:0]  ls_cut_i,
  input  logic             per_req_i,
  input  logic             cb_req_i,
  input  logic             ls_req_i,
  input  logic             busy_i,
  output grant_t           grant_o,
  output logic             per_prio_o
);
  localparam int unsigned PAD = CNT_W - LS_W;

  logic      prio_q;
  logic      ls_ok;
  xfer_cls_e pick;
  grant_t    grant_q, grant_d;

  // sticky for the frame once the start point is reached
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        prio_q <= 1'b0;
    else if (sof_i)                     prio_q <= 1'b0;
    else if (remain_i <= per_start_i)   prio_q <= 1'b1;
  end

  assign ls_ok = remain_i >= {{PAD{1'b0}}, ls_cut_i};

  always_comb begin
    pick = CLS_NONE;
    if (prio_q && per_req_i)   pick = CLS_PER;
    else if (cb_req_i)         pick = CLS_CB;
    else if (ls_req_i && ls_ok) pick = CLS_LS;
  end

  always_comb begin
    grant_d = '0;
    unique case (pick)
      CLS_PER: grant_d.per = 1'b1;
      CLS_CB:  grant_d.cb  = 1'b1;
      CLS_LS:  grant_d.ls  = 1'b1;
      default: ;
    endcase
  end

  // one decision per idle gap; busy takes a cycle to rise after a grant
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    grant_q <= '0;
    else if (busy_i || |grant_q)    grant_q <= '0;
    else                            grant_q <= grant_d;
  end

  assign grant_o    = grant_q;
  assign per_prio_o = prio_q;
endmodule

// File: rtl/frame_admit_gate.sv
module frame_admit_gate
  import frame_admit_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 14,
  parameter int unsigned LS_W   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              tick_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              per_req_i,
  input  logic              cb_req_i,
  input  logic              ls_req_i,
  input  logic              busy_i,
  output logic              per_grant_o,
  output logic              cb_grant_o,
  output logic              ls_grant_o,
  output logic              per_prio_o
);
  logic [CNT_W-1:0] frame_len, per_start, frame_rem;
  logic [LS_W-1:0]  ls_cut;
  grant_t           grant;

  fa_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .LS_W(LS_W)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .remain_i   (frame_rem),
    .frame_len_o(frame_len),
    .per_start_o(per_start),
    .ls_cut_o   (ls_cut),
    .rdata_o    (reg_rdata_o)
  );

  fa_frame_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .sof_i, .tick_i,
    .frame_len_i(frame_len),
    .remain_o   (frame_rem)
  );

  fa_arbiter #(.CNT_W(CNT_W), .LS_W(LS_W)) u_arb (
    .clk_i, .rst_ni, .sof_i,
    .remain_i   (frame_rem),
    .per_start_i(per_start),
    .ls_cut_i   (ls_cut),
    .per_req_i, .cb_req_i, .ls_req_i, .busy_i,
    .grant_o    (grant),
    .per_prio_o
  );

  assign per_grant_o = grant.per;
  assign cb_grant_o  = grant.cb;
  assign ls_grant_o  = grant.ls;
endmodule

// File: rtl/fa_checker.sv
module fa_checker #(
  parameter int unsigned CNT_W = 14,
  parameter int unsigned LS_W  = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sof_i,
  input logic             busy_i,
  input logic             per_grant_o,
  input logic             cb_grant_o,
  input logic             ls_grant_o,
  input logic             per_prio_o,
  input logic [CNT_W-1:0] remain,
  input logic [CNT_W-1:0] frame_len,
  input logic [LS_W-1:0]  ls_cut
);
  logic any_grant;
  assign any_grant = per_grant_o | cb_grant_o | ls_grant_o;

  // R10
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({per_grant_o, cb_grant_o, ls_grant_o}));

  // R10
  grant_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_grant |-> !$past(busy_i));

  // R10
  grant_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_grant |=> !any_grant);

  // R7
  per_needs_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_grant_o |-> $past(per_prio_o));

  // R9
  ls_cutoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ls_grant_o |-> ($past(remain) >= {{(CNT_W-LS_W){1'b0}}, $past(ls_cut)}));

  // R6
  prio_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(per_prio_o) |-> $past(sof_i));

  // R5
  rem_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> remain == $past(frame_len));
endmodule

bind frame_admit_gate fa_checker #(.CNT_W(CNT_W), .LS_W(LS_W)) u_chk (
  .clk_i, .rst_ni, .sof_i, .busy_i,
  .per_grant_o, .cb_grant_o, .ls_grant_o, .per_prio_o,
  .remain   (frame_rem),
  .frame_len(frame_len),
  .ls_cut   (ls_cut)
);

// File: tb/frame_admit_gate_test.sv
module frame_admit_gate_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sof_i = 1'b0, tick_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        per_req_i = 1'b0, cb_req_i = 1'b0, ls_req_i = 1'b0, busy_i = 1'b0;
  logic        per_grant_o, cb_grant_o, ls_grant_o, per_prio_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_admit_gate uut (
    .clk_i(clk), .rst_ni, .sof_i, .tick_i,
    .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .per_req_i, .cb_req_i, .ls_req_i, .busy_i,
    .per_grant_o, .cb_grant_o, .ls_grant_o, .per_prio_o
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] grants();
    return {29'd0, per_grant_o, cb_grant_o, ls_grant_o};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    reg_addr_i = a;
    #1;
    check(tag, reg_rdata_o, exp);
  endtask

  task automatic sof_pulse();
    sof_i = 1'b1;
    @(negedge clk);
    sof_i = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk);
    end
    tick_i = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R1 frame length", 8'h34, 32'h2EDF);
    rd_chk("R1 periodic start", 8'h40, 32'h0);
    rd_chk("R1 ls cutoff", 8'h44, 32'h628);
    check("R1 grants idle", grants(), 32'h0);
  endtask

  task automatic t_regs();
    wr(8'h40, 32'hFFFF_FFFF);
    rd_chk("R2 periodic start masked", 8'h40, 32'h3FFF);
    wr(8'h44, 32'hFFFF_FFFF);
    rd_chk("R3 ls cutoff masked", 8'h44, 32'h0FFF);
    wr(8'h50, 32'h1234_5678);
    rd_chk("R4 unmapped read", 8'h50, 32'h0);
    rd_chk("R4 unmapped write no effect ps", 8'h40, 32'h3FFF);
    rd_chk("R4 unmapped write no effect ls", 8'h44, 32'h0FFF);
    rd_chk("R4 unmapped write no effect len", 8'h34, 32'h2EDF);
    wr(8'h38, 32'h0000_0777);
    rd_chk("R4 remain read-only", 8'h38, 32'h0);
  endtask

  task automatic t_counter();
    wr(8'h34, 32'd100);
    sof_pulse();
    rd_chk("R5 load on sof", 8'h38, 32'd100);
    do_ticks(5);
    rd_chk("R5 decrement", 8'h38, 32'd95);
    repeat (3) @(negedge clk);
    rd_chk("R5 hold without tick", 8'h38, 32'd95);
    sof_i = 1'b1; tick_i = 1'b1;
    @(negedge clk);
    sof_i = 1'b0; tick_i = 1'b0;
    rd_chk("R5 sof beats tick", 8'h38, 32'd100);
    wr(8'h34, 32'd3);
    sof_pulse();
    do_ticks(6);
    rd_chk("R5 stops at zero", 8'h38, 32'd0);
  endtask

  task automatic t_prio();
    wr(8'h34, 32'd100);
    wr(8'h40, 32'd90);
    sof_pulse();
    check("R6 clear after sof", {31'd0, per_prio_o}, 32'd0);
    do_ticks(9);
    check("R6 low above start", {31'd0, per_prio_o}, 32'd0);
    do_ticks(1);
    check("R6 one edge latency", {31'd0, per_prio_o}, 32'd0);
    @(negedge clk);
    check("R6 set at start", {31'd0, per_prio_o}, 32'd1);
    do_ticks(5);
    check("R6 sticky", {31'd0, per_prio_o}, 32'd1);
    sof_pulse();
    check("R6 cleared by sof", {31'd0, per_prio_o}, 32'd0);
  endtask

  task automatic t_grant_order();
    wr(8'h34, 32'd100);
    wr(8'h40, 32'd50);
    sof_pulse();
    per_req_i = 1'b1; cb_req_i = 1'b1;
    @(negedge clk);
    check("R8 cb before start point", grants(), 32'b010);
    @(negedge clk);
    check("R10 no back-to-back grant", grants(), 32'b000);
    busy_i = 1'b1;
    @(negedge clk);
    check("R10 no grant while busy", grants(), 32'b000);
    do_ticks(50);
    @(negedge clk);
    check("R7 prio reached", {31'd0, per_prio_o}, 32'd1);
    check("R10 busy holds grants", grants(), 32'b000);
    busy_i = 1'b0;
    @(negedge clk);
    check("R7 periodic wins", grants(), 32'b100);
    @(negedge clk);
    check("R10 pulse one cycle", grants(), 32'b000);
    per_req_i = 1'b0;
    @(negedge clk);
    check("R7 cb after periodic", grants(), 32'b010);
    cb_req_i = 1'b0;
    @(negedge clk);
    sof_pulse();
    per_req_i = 1'b1;
    @(negedge clk);
    check("R8 periodic alone not granted", grants(), 32'b000);
    @(negedge clk);
    check("R8 periodic still held", grants(), 32'b000);
    per_req_i = 1'b0;
  endtask

  task automatic t_ls();
    wr(8'h44, 32'd40);
    wr(8'h34, 32'd100);
    sof_pulse();
    ls_req_i = 1'b1; cb_req_i = 1'b1;
    @(negedge clk);
    check("R9 cb beats low-speed", grants(), 32'b010);
    cb_req_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R9 low-speed granted", grants(), 32'b001);
    busy_i = 1'b1;
    do_ticks(60);
    rd_chk("R9 count at cutoff", 8'h38, 32'd40);
    busy_i = 1'b0;
    @(negedge clk);
    check("R9 granted at equal", grants(), 32'b001);
    busy_i = 1'b1;
    do_ticks(1);
    busy_i = 1'b0;
    @(negedge clk);
    check("R9 deferred below cutoff", grants(), 32'b000);
    @(negedge clk);
    check("R9 still deferred", grants(), 32'b000);
    ls_req_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_counter();
    t_prio();
    t_grant_order();
    t_ls();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule